// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets a host reach a small register space over three wires: an active-high transaction enable, a serial clock and a data line whose output half has its own enable. A transaction starts with an 8-bit command byte that gives the direction, the target space, the address and a write-protect bit. Data bytes follow, either one byte or a burst that streams the whole space from location 0 upward.

All three pins are synchronised into a fast system clock, and the serial clock's edges are detected there. Writes aimed at the scratch space land in an internal 31-byte RAM. Writes aimed at the clock/calendar space leave the block as a one-cycle strobe carrying an address and data. Reads from that space come back through a combinational data input. No back-pressure exists on either side. The host paces everything with the serial clock, and the register port must accept a strobe in the cycle it appears.

Top module: `tw_serial_slave`

## Requirements
- R1: When the enable pin is low, the transaction is abandoned. The data output enable is low within 3 system cycles, and the next transaction decodes a fresh command. A byte cut short by the enable going low is never written.
- R2: The serial data line is sampled on rising serial-clock edges. The first 8 samples after the enable rises form the command byte, least significant bit first.
- R3: When command bit 7 is 0, no RAM location and no clock/calendar register is modified.
- R4: When command bit 6 is 1, the internal RAM is the target. When it is 0, the clock/calendar port is the target (`reg_wr_o`, `reg_addr_o`, `reg_wdata_o`, `reg_rdata_i`).
- R5: Command bits 5..1 form the 5-bit address of a single-byte transfer.
- R6: When command bit 0 is 0, the transfer is a write. When it is 1, the transfer is a read.
- R7: Data bytes are shifted least significant bit first. A write is committed as a single-cycle strobe after the eighth rising edge of the byte.
- R8: During a read's data phase, the block drives the data line on each falling serial-clock edge with the next bit, and raises the output enable. The output enable is low in every other phase.
- R9: Address 31 selects a burst. The burst starts at location 0 and advances by one after each byte, for at most 31 bytes. Any further bytes are ignored.
- R10: In single-byte mode, serial clocks after the first data byte have no effect.
- R11: After reset, the output enable is low, no strobe is issued and every RAM byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Transaction enable pin, active high, asynchronous |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_dat_i | input | 1 | Serial data in |
| ser_dat_o | output | 1 | Serial data out |
| ser_dat_oe | output | 1 | Output enable for the data line |
| reg_wr_o | output | 1 | Clock/calendar write strobe, one cycle |
| reg_addr_o | output | 5 | Clock/calendar address (write address during a strobe, read address otherwise) |
| reg_wdata_o | output | 8 | Clock/calendar write data |
| reg_rdata_i | input | 8 | Clock/calendar read data for `reg_addr_o`, combinational |

## Verification
Every pin passes through two synchroniser stages, and one more register stands between those stages and each output. So a write strobe appears 3 system cycles after the rising serial edge that completes a byte. A read bit is driven 3 cycles after the falling edge, and the output enable drops 3 cycles after the enable pin falls. The host model holds each serial-clock phase for 8 system cycles. It samples read data just before it raises the clock, well after the 3-cycle delay. It checks the output enable only once the enable pin has been low for 4 cycles. Strobes are compared against a queue of expected writes in the cycle they occur, and RAM effects are checked by reading them back.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CMD_W  = ADDR_W + 3;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic              wen;      // bit 7: write permitted
    logic              ram_sel;  // bit 6: 1 = scratch RAM
    logic [ADDR_W-1:0] addr;     // bits 5..1
    logic              rd;       // bit 0: 1 = read
  } cmd_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/tw_ram.sv
module tw_ram #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int DEPTH = (1 << AW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              mem[i] <= '0;
        else if (we_i && waddr_i == AW'(i))      mem[i] <= wdata_i;
    end
  endgenerate

  assign rdata_o = (raddr_i <= TOP) ? mem[raddr_i] : '0;
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_stb_o,
  output logic              wr_ram_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_ram_o,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2((CMD_W > DATA_W) ? CMD_W : DATA_W);
  localparam logic [ADDR_W-1:0] BURST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LAST  = BURST - 1'b1;

  logic              sclk_q;
  logic              rise, fall;
  phase_e            ph;
  cmd_t              cmd_q;
  logic [CMD_W-1:0]  csh;
  logic [DATA_W-1:0] dsh;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              burst_q;
  cmd_t              new_cmd;
  logic [DATA_W-1:0] new_data;
  logic              byte_end;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign new_cmd  = cmd_t'({din_s, csh[CMD_W-1:1]});
  assign new_data = {din_s, dsh[DATA_W-1:1]};
  assign byte_end = (cnt == CNT_W'(DATA_W - 1));

  assign wr_ram_o  = cmd_q.ram_sel;
  assign rd_ram_o  = cmd_q.ram_sel;
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      ph        <= PH_CMD;
      cmd_q     <= '0;
      csh       <= '0;
      dsh       <= '0;
      cnt       <= '0;
      addr_q    <= '0;
      burst_q   <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      dout_o    <= 1'b0;
      oe_o      <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      wr_stb_o <= 1'b0;
      if (!en_s) begin
        ph   <= PH_CMD;
        cnt  <= '0;
        oe_o <= 1'b0;
      end else begin
        if (rise) begin
          case (ph)
            PH_CMD: begin
              csh <= new_cmd;
              if (cnt == CNT_W'(CMD_W - 1)) begin
                cmd_q   <= new_cmd;
                ph      <= PH_DATA;
                cnt     <= '0;
                burst_q <= (new_cmd.addr == BURST);
                addr_q  <= (new_cmd.addr == BURST) ? '0 : new_cmd.addr;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DATA: begin
              dsh <= new_data;
              if (byte_end) begin
                if (!cmd_q.rd) begin
                  wr_stb_o  <= cmd_q.wen;
                  wr_data_o <= new_data;
                  wr_addr_o <= addr_q;
                end
                cnt <= '0;
                if (burst_q && addr_q != LAST) begin
                  addr_q <= addr_q + 1'b1;
                end else begin
                  ph   <= PH_DONE;
                  oe_o <= 1'b0;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (fall && ph == PH_DATA && cmd_q.rd) begin
          dout_o <= rd_data_i[cnt];
          oe_o   <= 1'b1;
        end
      end
    end
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R7
  AST_STB_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(rise)); // R7
  AST_STB_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> cmd_q.wen); // R3
  AST_STB_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !cmd_q.rd); // R6
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (cmd_q.rd && ph != PH_CMD)); // R8
  AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (wr_addr_o <= LAST)); // R9
endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int SYNC_STAGES = 2;
  localparam int RAM_DEPTH   = (1 << ADDR_W) - 1;

  logic [2:0]        pins_s;
  logic              wr_stb, wr_ram, rd_ram;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, ram_rdata, rd_data;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_en_i, ser_clk_i, ser_dat_i}),
    .sync_o  (pins_s)
  );

  tw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .din_s     (pins_s[0]),
    .rd_data_i (rd_data),
    .wr_stb_o  (wr_stb),
    .wr_ram_o  (wr_ram),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .rd_ram_o  (rd_ram),
    .dout_o    (ser_dat_o),
    .oe_o      (ser_dat_oe)
  );

  tw_ram #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_stb & wr_ram),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr),
    .rdata_o (ram_rdata)
  );

  assign rd_data     = rd_ram ? ram_rdata : reg_rdata_i;
  assign reg_wr_o    = wr_stb & ~wr_ram;
  assign reg_addr_o  = wr_stb ? wr_addr : rd_addr;
  assign reg_wdata_o = wr_data;

  AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en_i && !$past(ser_en_i) && !$past(ser_en_i, 2)) |=> !ser_dat_oe); // R1
endmodule

// File: tb/tw_serial_slave_tb.sv
module tw_serial_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en_i = 1'b0;
  logic       ser_clk_i = 1'b0;
  logic       ser_dat_i = 1'b0;
  logic       ser_dat_o, ser_dat_oe, reg_wr_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;

  logic [7:0]  clk_bank [32];   // peripheral side, written by strobes
  logic [7:0]  clk_m    [32];   // expected clock/calendar contents
  logic [7:0]  ram_m    [31];   // expected RAM contents
  logic [12:0] exp_q [$];       // expected strobes {addr,data}
  int n_cmp = 0;
  int n_bad = 0;
  int en_lo_cnt = 0;

  always #2.5 clk = ~clk;

  tw_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_i(ser_en_i), .ser_clk_i(ser_clk_i),
    .ser_dat_i(ser_dat_i), .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe),
    .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = clk_bank[reg_addr_o];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock monitor: strobes against the queue, output enable while idle
  always @(negedge clk) begin
    if (rst_n) begin
      en_lo_cnt = ser_en_i ? 0 : en_lo_cnt + 1;
      if (en_lo_cnt >= 4) chk(!ser_dat_oe, "R1 oe released", ser_dat_oe, 0);
      if (reg_wr_o) begin
        if (exp_q.size() == 0) chk(0, "R3/R10 unexpected strobe", {reg_addr_o, reg_wdata_o}, 0);
        else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          chk({reg_addr_o, reg_wdata_o} == e, "R4/R7 strobe addr,data", {reg_addr_o, reg_wdata_o}, e);
        end
        clk_bank[reg_addr_o] = reg_wdata_o;
        @(negedge clk);
        chk(!reg_wr_o, "R7 strobe single cycle", reg_wr_o, 0);
      end
    end
  end

  task automatic sbit(input logic d, output logic q, output logic oe);
    @(negedge clk) ser_dat_i = d;
    repeat (7) @(negedge clk);
    q  = ser_dat_o;
    oe = ser_dat_oe;
    ser_clk_i = 1'b1;
    repeat (8) @(negedge clk);
    ser_clk_i = 1'b0;
  endtask

  task automatic start_t();
    @(negedge clk) ser_en_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic stop_t();
    @(negedge clk) ser_en_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input bit wen, input bit ram, input int a, input bit rd);
    return {wen, ram, 5'(a), rd};
  endfunction

  task automatic send_byte(input logic [7:0] b);
    logic q, oe;
    for (int i = 0; i < 8; i++) sbit(b[i], q, oe);
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit oe_all);
    logic q, oe;
    oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      sbit(1'b0, q, oe);
      b[i] = q;
      if (!oe) oe_all = 0;
    end
  endtask

  task automatic read_one(input bit ram, input int a, input logic [7:0] exp, input string tag);
    logic [7:0] b; bit oe_all;
    start_t(); send_byte(mk(1, ram, a, 1)); recv_byte(b, oe_all); stop_t();
    chk(b == exp, tag, b, exp);
    chk(oe_all, "R8 oe during read", oe_all, 1);
  endtask

  task automatic write_one(input bit wen, input bit ram, input int a, input logic [7:0] d);
    start_t(); send_byte(mk(wen, ram, a, 0)); send_byte(d); stop_t();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin clk_bank[i] = 8'h00; clk_m[i] = 8'h00; end
    for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(!ser_dat_oe && !reg_wr_o, "R11 reset outputs", {ser_dat_oe, reg_wr_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_one(1, 12, 8'h00, "R11 RAM cleared");

    // R2 R5 R6 R7: single RAM write, read back
    write_one(1, 1, 5, 8'hA5); ram_m[5] = 8'hA5;
    read_one(1, 5, 8'hA5, "R2/R5/R7 RAM byte");
    write_one(1, 1, 6, 8'h3C); ram_m[6] = 8'h3C;
    read_one(1, 6, 8'h3C, "R5 RAM neighbour");
    read_one(1, 5, 8'hA5, "R5 RAM addr kept");

    // R4: clock/calendar space goes to the port
    exp_q.push_back({5'd3, 8'h5E}); clk_m[3] = 8'h5E;
    write_one(1, 0, 3, 8'h5E);
    chk(exp_q.size() == 0, "R4 clock strobe seen", exp_q.size(), 0);
    read_one(0, 3, clk_m[3], "R4/R6 clock read");
    read_one(1, 3, ram_m[3], "R4 RAM untouched by clock write");

    // R3: write-protected commands
    write_one(0, 1, 5, 8'h00);
    read_one(1, 5, ram_m[5], "R3 protected RAM write");
    write_one(0, 0, 3, 8'hFF);
    read_one(0, 3, clk_m[3], "R3 protected clock write");

    // R10: extra clocks after a single byte
    start_t(); send_byte(mk(1, 1, 7, 0)); send_byte(8'h81); send_byte(8'h7E); stop_t();
    ram_m[7] = 8'h81;
    read_one(1, 7, 8'h81, "R10 RAM extra byte ignored");
    read_one(1, 8, ram_m[8], "R10 next RAM byte untouched");
    exp_q.push_back({5'd9, 8'h44}); clk_m[9] = 8'h44;
    start_t(); send_byte(mk(1, 0, 9, 0)); send_byte(8'h44); send_byte(8'h99); stop_t();
    chk(exp_q.size() == 0, "R10 one clock strobe", exp_q.size(), 0);

    // R1: abort mid-byte and mid-command
    start_t(); send_byte(mk(1, 1, 9, 0));
    begin logic q, oe; for (int i = 0; i < 4; i++) sbit(1'b1, q, oe); end
    stop_t();
    read_one(1, 9, ram_m[9], "R1 aborted byte not written");
    start_t();
    begin logic q, oe; for (int i = 0; i < 3; i++) sbit(1'b1, q, oe); end
    stop_t();
    read_one(1, 5, ram_m[5], "R1 fresh command after abort");

    // R9: burst write 32 bytes (last ignored), burst read
    start_t(); send_byte(mk(1, 1, 31, 0));
    for (int i = 0; i < 32; i++) send_byte(8'(i * 7 + 1));
    stop_t();
    for (int i = 0; i < 31; i++) ram_m[i] = 8'(i * 7 + 1);
    read_one(1, 0, ram_m[0], "R9 burst starts at 0");
    read_one(1, 30, ram_m[30], "R9 burst last byte");
    start_t(); send_byte(mk(1, 1, 31, 1));
    for (int i = 0; i < 31; i++) begin
      logic [7:0] b; bit oe_all;
      recv_byte(b, oe_all);
      chk(b == ram_m[i], "R9 burst read", b, ram_m[i]);
      chk(oe_all, "R8 oe in burst read", oe_all, 1);
    end
    stop_t();

    // R9: burst in clock space, strobes at 0,1,2
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back({5'(i), 8'(8'hC0 + i)}); clk_m[i] = 8'(8'hC0 + i);
    end
    start_t(); send_byte(mk(1, 0, 31, 0));
    for (int i = 0; i < 3; i++) send_byte(8'(8'hC0 + i));
    stop_t();
    chk(exp_q.size() == 0, "R9 clock burst strobes", exp_q.size(), 0);
    read_one(0, 2, clk_m[2], "R9 clock burst readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule